// File: doc/BRIEF.md
# Predicated Merging Vector Adder

This block adds two integer source vectors lane by lane and writes the sums only into the lanes that a per-lane predicate enables. Every other lane passes the current destination contents through unchanged. The vector width is a build-time parameter. A 2-bit code picks the element size for each operation. The lane count therefore changes from one operation to the next, and so does the set of predicate bits that mean anything.

A pipeline stage gives it an operation as one beat. That beat carries both sources, the old destination value, the predicate mask and the size code, qualified by a valid strobe. One clock later the block returns the merged destination vector with a valid flag. The result then stays on the output until the next beat.

Top module: `pred_vadd`

## Requirements
- R1: The width parameter `VEC_W` is a multiple of 128 in the range 128 to 2048. The predicate input has `VEC_W/8` bits, which is one bit per lane at the smallest element size.
- R2: `in_esize` selects the element width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. The vector holds `VEC_W/width` lanes.
- R3: An enabled lane receives (a + b) mod 2^width. No carry crosses a lane boundary.
- R4: Lane i occupies bits [i*width +: width] of every vector operand and is gated by predicate bit i. Bit 0 gates the lowest lane.
- R5: A lane whose predicate bit is 0 outputs its `in_old` contents unchanged.
- R6: Predicate bits with an index of `VEC_W/width` or higher have no effect on the result.
- R7: When the predicate is all zero, `out_dat` equals `in_old` bit for bit.
- R8: `out_vld` and the result appear exactly one clock after a cycle with `in_vld` high. `out_vld` is low one clock after a cycle with `in_vld` low.
- R9: A synchronous active-high `rst` clears `out_vld` and `out_dat` to zero on the next clock edge.
- R10: `out_dat` holds its value across cycles in which `in_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation valid strobe |
| in_esize | input | 2 | Element size code |
| in_pred | input | VEC_W/8 | Lane predicate, bit i gates lane i |
| in_a | input | VEC_W | First source vector |
| in_b | input | VEC_W | Second source vector |
| in_old | input | VEC_W | Current destination vector |
| out_vld | output | 1 | Result valid |
| out_dat | output | VEC_W | Merged destination vector |

## Verification
The assertions check on every cycle the one-clock valid timing, the holding of the output between beats, the reset clearing, and the all-lanes-off pass-through. They also check the lowest byte: a sum when predicate bit 0 is set, and the old value when it is clear. Only the bench scenarios can show the per-lane behaviour across the vector. This covers the carry cut at each element boundary for all four sizes, the ascending predicate-to-lane order, and the fact that predicate bits above the lane count are ignored. The bench checks these against a lane model computed from the size code.

// File: rtl/vadd_pkg.sv
package vadd_pkg;

  typedef enum logic [1:0] {
    ES_B8  = 2'b00,
    ES_B16 = 2'b01,
    ES_B32 = 2'b10,
    ES_B64 = 2'b11
  } esize_e;

  localparam int unsigned MIN_VEC_W  = 128;
  localparam int unsigned MAX_VEC_W  = 2048;
  localparam int unsigned VEC_GRAIN  = 128;
  localparam int unsigned BYTE_W     = 8;

  // Bytes per element for a size code.
  function automatic int unsigned elem_bytes(input esize_e es);
    return 1 << es;
  endfunction

  // True when byte index bi starts a new element for the code es.
  function automatic logic starts_elem(input int unsigned bi, input esize_e es);
    return (bi % elem_bytes(es)) == 0;
  endfunction

endpackage

// File: rtl/vadd_seg_adder.sv
module vadd_seg_adder
  import vadd_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  esize_e           esize,
  output logic [VEC_W-1:0] sum
);

  localparam int unsigned NBYTES = VEC_W / BYTE_W;

  logic [NBYTES-1:0] cout;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    // Element starts at this byte for each size code (constant per byte).
    localparam logic CUT16 = (g % 2) == 0;
    localparam logic CUT32 = (g % 4) == 0;
    localparam logic CUT64 = (g % 8) == 0;

    logic       cut;
    logic       cin;
    logic [8:0] part;

    always_comb begin
      unique case (esize)
        ES_B8:   cut = 1'b1;
        ES_B16:  cut = CUT16;
        ES_B32:  cut = CUT32;
        default: cut = CUT64;
      endcase
    end

    if (g == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_rest
      assign cin = cut ? 1'b0 : cout[g-1];
    end

    assign part = {1'b0, a[g*BYTE_W +: BYTE_W]} + {1'b0, b[g*BYTE_W +: BYTE_W]} + {8'd0, cin};
    assign sum[g*BYTE_W +: BYTE_W] = part[7:0];
    assign cout[g] = part[8];
  end

endmodule

// File: rtl/vadd_lane_enable.sv
module vadd_lane_enable
  import vadd_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic [VEC_W/8-1:0] pred,
  input  esize_e             esize,
  output logic [VEC_W/8-1:0] byte_en
);

  localparam int unsigned NBYTES = VEC_W / BYTE_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    // Lane index owning byte g for each element size.
    localparam int unsigned L8  = g;
    localparam int unsigned L16 = g / 2;
    localparam int unsigned L32 = g / 4;
    localparam int unsigned L64 = g / 8;

    always_comb begin
      unique case (esize)
        ES_B8:   byte_en[g] = pred[L8];
        ES_B16:  byte_en[g] = pred[L16];
        ES_B32:  byte_en[g] = pred[L32];
        default: byte_en[g] = pred[L64];
      endcase
    end
  end

endmodule

// File: rtl/vadd_merge.sv
module vadd_merge
  import vadd_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic [VEC_W-1:0]   sum,
  input  logic [VEC_W-1:0]   old,
  input  logic [VEC_W/8-1:0] byte_en,
  output logic [VEC_W-1:0]   merged
);

  localparam int unsigned NBYTES = VEC_W / BYTE_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign merged[g*BYTE_W +: BYTE_W] = byte_en[g] ? sum[g*BYTE_W +: BYTE_W]
                                                   : old[g*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/pred_vadd.sv
module pred_vadd
  import vadd_pkg::*;
#(
  parameter int unsigned VEC_W = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [1:0]         in_esize,
  input  logic [VEC_W/8-1:0] in_pred,
  input  logic [VEC_W-1:0]   in_a,
  input  logic [VEC_W-1:0]   in_b,
  input  logic [VEC_W-1:0]   in_old,
  output logic               out_vld,
  output logic [VEC_W-1:0]   out_dat
);

  localparam int unsigned NBYTES = VEC_W / BYTE_W;

  esize_e             es;
  logic [VEC_W-1:0]   sum;
  logic [NBYTES-1:0]  byte_en;
  logic [VEC_W-1:0]   merged;

  assign es = esize_e'(in_esize);

  vadd_seg_adder #(.VEC_W(VEC_W)) add_i (
    .a     (in_a),
    .b     (in_b),
    .esize (es),
    .sum   (sum)
  );

  vadd_lane_enable #(.VEC_W(VEC_W)) en_i (
    .pred    (in_pred),
    .esize   (es),
    .byte_en (byte_en)
  );

  vadd_merge #(.VEC_W(VEC_W)) mrg_i (
    .sum     (sum),
    .old     (in_old),
    .byte_en (byte_en),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_dat <= merged;
    end
  end

endmodule

// File: rtl/pred_vadd_chk.sv
module pred_vadd_chk #(
  parameter int unsigned VEC_W = 256
) (
  input logic               clk,
  input logic               rst,
  input logic               in_vld,
  input logic [VEC_W/8-1:0] in_pred,
  input logic [VEC_W-1:0]   in_a,
  input logic [VEC_W-1:0]   in_b,
  input logic [VEC_W-1:0]   in_old,
  input logic               out_vld,
  input logic [VEC_W-1:0]   out_dat
);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  a_r8_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_dat));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_vld && out_dat == '0));

  a_r7_all_off: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_pred == '0) |=> out_dat == $past(in_old));

  a_r5_lane0_keep: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_pred[0]) |=> out_dat[7:0] == $past(in_old[7:0]));

  a_r3_lane0_sum: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_pred[0]) |=> out_dat[7:0] == $past(8'(in_a[7:0] + in_b[7:0])));

endmodule

bind pred_vadd pred_vadd_chk #(.VEC_W(VEC_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .in_pred (in_pred),
  .in_a    (in_a),
  .in_b    (in_b),
  .in_old  (in_old),
  .out_vld (out_vld),
  .out_dat (out_dat)
);

// File: tb/pred_vadd_tb_top.sv
module pred_vadd_tb_top;

  localparam int unsigned W  = 256;
  localparam int unsigned PW = W / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [1:0]    in_esize = 2'b00;
  logic [PW-1:0] in_pred = '0;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic [W-1:0]  in_old = '0;
  logic          out_vld;
  logic [W-1:0]  out_dat;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pred_vadd #(.VEC_W(W)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_esize(in_esize),
    .in_pred(in_pred), .in_a(in_a), .in_b(in_b), .in_old(in_old),
    .out_vld(out_vld), .out_dat(out_dat)
  );

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] d;
    logic [31:0] p;
    logic [1:0]  es;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{64'h0123456789ABCDEF, 64'h1111111111111111, 64'hDEADBEEFCAFEF00D, 32'hFFFFFFFF, 2'b00},
    '{64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h0000000000000000, 32'hFFFFFFFF, 2'b00},
    '{64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h5555555555555555, 32'h0000FFFF, 2'b01},
    '{64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h5555555555555555, 32'h000000FF, 2'b10},
    '{64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 64'h5555555555555555, 32'h0000000F, 2'b11},
    '{64'h8080808080808080, 64'h8181818181818181, 64'hA5A5A5A5A5A5A5A5, 32'hAAAAAAAA, 2'b00},
    '{64'h7FFF00FF12345678, 64'h0001FF0100010001, 64'hCCCCCCCCCCCCCCCC, 32'h00000005, 2'b01},
    '{64'h00000000FFFFFFFF, 64'h0000000000000001, 64'h3333333333333333, 32'h00000009, 2'b11}
  };

  // Lane model built from R2..R6.
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [W-1:0] d, input logic [PW-1:0] p,
                                         input logic [1:0] es);
    logic [W-1:0] r;
    int unsigned  w;
    int unsigned  n;
    logic [63:0]  m;
    logic [63:0]  ea;
    logic [63:0]  eb;
    logic [63:0]  s;
    r = d;
    w = 8 << es;
    n = W / w;
    m = (w == 64) ? 64'hFFFFFFFFFFFFFFFF : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < int'(n); i++) begin
      if (p[i]) begin
        ea = 64'(a >> (i * w)) & m;
        eb = 64'(b >> (i * w)) & m;
        s  = (ea + eb) & m;
        r  = (r & ~(W'(m) << (i * w))) | (W'(s) << (i * w));
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d,
                       input logic [PW-1:0] p, input logic [1:0] es);
    @(negedge clk);
    in_a = a; in_b = b; in_old = d; in_pred = p; in_esize = es; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] a, b, d, snap;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_vld in reset", W'(out_vld), W'(0));
    check("R9 out_dat in reset", out_dat, '0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      a = {4{TBL[k].a}}; b = {4{TBL[k].b}}; d = {4{TBL[k].d}};
      issue(a, b, d, TBL[k].p, TBL[k].es);
      check($sformatf("R8 valid entry %0d", k), W'(out_vld), W'(1));
      check($sformatf("R2/R3/R5 table entry %0d", k), out_dat,
            model(a, b, d, TBL[k].p, TBL[k].es));
    end

    // R8: valid low one cycle after strobe low
    @(negedge clk);
    check("R8 valid drops", W'(out_vld), W'(0));

    // R10: output holds with no strobe
    snap = out_dat;
    repeat (3) @(negedge clk);
    check("R10 hold", out_dat, snap);

    // R4: predicate bit 0 gates the lowest 32-bit lane only
    a = {W/32{32'h00000010}}; b = {W/32{32'h00000001}}; d = {W/32{32'hEEEEEEEE}};
    issue(a, b, d, 32'h00000001, 2'b10);
    check("R4 bit0 -> lane0", out_dat, {{(W/32-1){32'hEEEEEEEE}}, 32'h00000011});

    // R6: bits beyond 4 lanes at 64-bit size are ignored
    issue(a, b, d, 32'hFFFFFFF0, 2'b11);
    check("R6 high bits ignored", out_dat, d);

    // R7: all-zero predicate passes old vector
    issue({W/8{8'h5A}}, {W/8{8'h33}}, {W/8{8'hC3}}, '0, 2'b00);
    check("R7 all off", out_dat, {W/8{8'hC3}});

    // R3: byte wrap with no carry into neighbour
    issue({{(W/8-1){8'h00}}, 8'hFF}, {{(W/8-1){8'h00}}, 8'h01}, '0, {PW{1'b1}}, 2'b00);
    check("R3 byte wrap", out_dat, '0);

    // R1: every byte lane addressable at 8-bit size, top lane via top bit
    issue({W/8{8'h01}}, {W/8{8'h02}}, {W/8{8'h00}}, {1'b1, {(PW-1){1'b0}}}, 2'b00);
    check("R1 top byte lane", out_dat, {8'h03, {(W/8-1){8'h00}}});

    // R9: synchronous reset mid-run clears output
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears data", out_dat, '0);
    rst = 1'b0;

    finish_run();
  end

endmodule